// File: doc/BRIEF.md
# Register-Format Integer Execute Unit

This block is the combinational execute step for a 32-bit load/store processor. It receives one instruction word and the two operand values that the register file has already read for that word. It decodes the word, runs the operation, and returns three things: a 32-bit result, the index of the register to write, and a write-enable. The register file, memory access, branches, fetch and any pipeline registers are all outside this block.

The unit supports the two-source register forms: add, subtract, AND, OR, NOR, signed set-less-than, and logical shifts in both directions. It also supports five forms that take a 16-bit constant: add, signed set-less-than, AND, OR and load-upper. There is no separate NOT operation, because NOR with a zero operand gives the complement. Arithmetic wraps modulo 2^32 and never raises an exception.

Top module: `int_exec_unit`

## Requirements
- R1: A register-format word is split into the fields opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. When opcode is 000000 and funct is 100000, the result is rs_val + rt_val (mod 2^32) and the destination is rd.
- R2: With opcode 000000, funct 100010 gives rs_val - rt_val (mod 2^32), funct 100100 gives rs_val AND rt_val, and funct 100101 gives rs_val OR rt_val. Each writes rd.
- R3: With opcode 000000, funct 100111 gives NOT (rs_val OR rt_val). When rt_val is zero, this is the bitwise complement of rs_val.
- R4: With opcode 000000, funct 101010 gives 1 when rs_val < rt_val as two's-complement numbers, and 0 otherwise.
- R5: With opcode 000000, funct 000000 shifts rt_val left by shamt, and funct 000010 shifts rt_val right by shamt. Vacated bits are filled with zeros, and rs_val has no effect.
- R6: Opcode 001000 gives rs_val plus the sign-extended constant in [15:0]. The destination is rt, and bits [15:11] are not used as a register index.
- R7: Opcode 001010 gives 1 when rs_val is less than the sign-extended constant, both taken as signed, and 0 otherwise. The destination is rt.
- R8: Opcode 001100 gives rs_val AND the zero-extended constant, and opcode 001101 gives rs_val OR the zero-extended constant. The destination is rt.
- R9: Opcode 001111 places the constant in bits [31:16] and zeros in bits [15:0]. The destination is rt.
- R10: Any other opcode, or any other funct under opcode 000000, drives write-enable to 0 and the result to 0.
- R11: Write-enable is 0 whenever the selected destination index is 0, even though the result is still computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Value read for the rs field |
| rt_val | input | 32 | Value read for the rt field |
| result | output | 32 | Computed result |
| dest_idx | output | 5 | Register index to write (rd or rt) |
| wr_en | output | 1 | Result should be written to dest_idx |

## Verification
The block holds no state, so a decode fault shows up at the ports in the same cycle the word is applied. It can appear in three ways: the wrong destination field, such as rd taken for an immediate form; a write-enable raised for an illegal or register-zero target; or a wrong result. The most likely faults are a wrong extension kind for a constant, an unsigned compare where a signed one is required, and a shift stage that brings in ones or moves the wrong distance. Every vector is therefore checked against an independent model on all three outputs at once. The vectors include sign-boundary operands, shift amounts 0 and 31, and funct and opcode values just outside the legal set.

// File: rtl/ieu_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the integer execute unit.
// Assumes the fixed 32-bit word layout with a 6-bit opcode and a 6-bit funct.
package ieu_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int SHAMT_W = 5;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_RFMT = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_SLTI = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'b001111;

    localparam logic [FUNCT_W-1:0] FN_SLL = 6'b000000;
    localparam logic [FUNCT_W-1:0] FN_SRL = 6'b000010;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_NOR = 6'b100111;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI, ALU_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_NONE, IMM_SEXT, IMM_ZEXT
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   op;
        imm_kind_e imm;
        logic      dest_is_rt;
        logic      legal;
    } ctrl_t;

endpackage

// File: rtl/ieu_field_split.sv
`timescale 1ns/1ps
// Splits an instruction word into its fixed-position fields.
// Assumes the 6/5/5/5/5/6 layout; the 16-bit constant overlays rd/shamt/funct.
module ieu_field_split
    import ieu_pkg::*;
(
    input  logic [INSN_W-1:0]  instr,
    output logic [OPC_W-1:0]   opcode,
    output logic [REG_W-1:0]   rt_idx,
    output logic [REG_W-1:0]   rd_idx,
    output logic [SHAMT_W-1:0] shamt,
    output logic [FUNCT_W-1:0] funct,
    output logic [IMM_W-1:0]   imm
);

    localparam int OPC_LSB   = INSN_W - OPC_W;
    localparam int RS_LSB    = OPC_LSB - REG_W;
    localparam int RT_LSB    = RS_LSB - REG_W;
    localparam int RD_LSB    = RT_LSB - REG_W;
    localparam int SHAMT_LSB = RD_LSB - SHAMT_W;

    // The rs index is resolved by the register file upstream, not here.
    logic [REG_W-1:0] unused_rs;

    // Slice every field out of the word.
    always_comb begin
        opcode    = instr[OPC_LSB +: OPC_W];
        unused_rs = instr[RS_LSB +: REG_W];
        rt_idx    = instr[RT_LSB +: REG_W];
        rd_idx    = instr[RD_LSB +: REG_W];
        shamt     = instr[SHAMT_LSB +: SHAMT_W];
        funct     = instr[0 +: FUNCT_W];
        imm       = instr[0 +: IMM_W];
    end

endmodule

// File: rtl/ieu_decode.sv
`timescale 1ns/1ps
// Maps opcode/funct onto an ALU operation, a constant-extension kind and a
// destination choice. Unrecognised encodings come out with legal = 0.
module ieu_decode
    import ieu_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    output ctrl_t              ctrl
);

    // Select the operation for the register format or an immediate form.
    always_comb begin
        ctrl.op         = ALU_NONE;
        ctrl.imm        = IMM_NONE;
        ctrl.dest_is_rt = 1'b1;
        ctrl.legal      = 1'b0;
        if (opcode == OPC_RFMT) begin
            ctrl.dest_is_rt = 1'b0;
            ctrl.legal      = 1'b1;
            case (funct)
                FN_ADD:  ctrl.op = ALU_ADD;
                FN_SUB:  ctrl.op = ALU_SUB;
                FN_AND:  ctrl.op = ALU_AND;
                FN_OR:   ctrl.op = ALU_OR;
                FN_NOR:  ctrl.op = ALU_NOR;
                FN_SLT:  ctrl.op = ALU_SLT;
                FN_SLL:  ctrl.op = ALU_SLL;
                FN_SRL:  ctrl.op = ALU_SRL;
                default: ctrl.legal = 1'b0;
            endcase
        end else begin
            ctrl.legal = 1'b1;
            case (opcode)
                OPC_ADDI: begin ctrl.op = ALU_ADD; ctrl.imm = IMM_SEXT; end
                OPC_SLTI: begin ctrl.op = ALU_SLT; ctrl.imm = IMM_SEXT; end
                OPC_ANDI: begin ctrl.op = ALU_AND; ctrl.imm = IMM_ZEXT; end
                OPC_ORI:  begin ctrl.op = ALU_OR;  ctrl.imm = IMM_ZEXT; end
                OPC_LUI:  ctrl.op = ALU_LUI;
                default:  ctrl.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ieu_operand_sel.sv
`timescale 1ns/1ps
// Chooses the second ALU operand: the rt value, or the 16-bit constant
// widened by sign or zero extension. Assumes DATA_W >= IMM_W.
module ieu_operand_sel
    import ieu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  imm_kind_e          kind,
    input  logic [IMM_W-1:0]   imm,
    input  logic [DATA_W-1:0]  rt_val,
    output logic [DATA_W-1:0]  opnd_b
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    generate
        if (EXT_W > 0) begin : g_widen
            // Widen the constant both ways.
            always_comb begin
                imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
                imm_zext = {{EXT_W{1'b0}}, imm};
            end
        end else begin : g_same
            // Constant already fills the datapath.
            always_comb begin
                imm_sext = imm[DATA_W-1:0];
                imm_zext = imm[DATA_W-1:0];
            end
        end
    endgenerate

    // Pick the operand by extension kind.
    always_comb begin
        case (kind)
            IMM_SEXT: opnd_b = imm_sext;
            IMM_ZEXT: opnd_b = imm_zext;
            default:  opnd_b = rt_val;
        endcase
    end

endmodule

// File: rtl/ieu_shifter.sv
`timescale 1ns/1ps
// Logarithmic logical shifter; one stage per shift-amount bit, zero fill.
// Assumes SH_W = log2(DATA_W).
module ieu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] value,
    input  logic [SH_W-1:0]   amount,
    input  logic              to_left,
    output logic [DATA_W-1:0] shifted
);

    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = value;

    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            // Move by 2^k when this amount bit is set.
            always_comb begin
                if (!amount[k])
                    stage[k+1] = stage[k];
                else if (to_left)
                    stage[k+1] = {stage[k][DATA_W-DIST-1:0], {DIST{1'b0}}};
                else
                    stage[k+1] = {{DIST{1'b0}}, stage[k][DATA_W-1:DIST]};
            end
        end
    endgenerate

    assign shifted = stage[SH_W];

endmodule

// File: rtl/ieu_alu.sv
`timescale 1ns/1ps
// Computes the result for a decoded operation. Add/sub wrap; set-less-than
// is signed; shifts act on operand b; load-upper uses the raw constant.
module ieu_alu
    import ieu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   shamt,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result
);

    localparam int LOW_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] shift_out;
    logic              less;

    ieu_shifter #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W)
    ) u_shift (
        .value   (opnd_b),
        .amount  (shamt),
        .to_left (op == ALU_SLL),
        .shifted (shift_out)
    );

    // Signed comparison of the two operands.
    always_comb less = ($signed(opnd_a) < $signed(opnd_b));

    // Result multiplexer by operation.
    always_comb begin
        case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_AND: result = opnd_a & opnd_b;
            ALU_OR:  result = opnd_a | opnd_b;
            ALU_NOR: result = ~(opnd_a | opnd_b);
            ALU_SLT: result = {{(DATA_W-1){1'b0}}, less};
            ALU_SLL: result = shift_out;
            ALU_SRL: result = shift_out;
            ALU_LUI: result = {imm, {LOW_W{1'b0}}};
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
// Combinational integer execute unit: decodes one word, runs it on the two
// source values and reports result, destination index and write-enable.
// Assumes the operands were read by the register file for rs and rt.
module int_exec_unit
    import ieu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] result,
    output logic [REG_W-1:0]  dest_idx,
    output logic              wr_en
);

    localparam int SH_W = $clog2(DATA_W);

    logic [OPC_W-1:0]   opcode;
    logic [REG_W-1:0]   rt_idx;
    logic [REG_W-1:0]   rd_idx;
    logic [SHAMT_W-1:0] shamt;
    logic [FUNCT_W-1:0] funct;
    logic [IMM_W-1:0]   imm;
    ctrl_t              ctrl;
    logic [DATA_W-1:0]  opnd_b;
    logic [DATA_W-1:0]  alu_out;

    ieu_field_split u_split (
        .instr  (instr),
        .opcode (opcode),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .shamt  (shamt),
        .funct  (funct),
        .imm    (imm)
    );

    ieu_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    ieu_operand_sel #(.DATA_W(DATA_W)) u_opsel (
        .kind   (ctrl.imm),
        .imm    (imm),
        .rt_val (rt_val),
        .opnd_b (opnd_b)
    );

    ieu_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) u_alu (
        .op     (ctrl.op),
        .opnd_a (rs_val),
        .opnd_b (opnd_b),
        .shamt  (shamt[SH_W-1:0]),
        .imm    (imm),
        .result (alu_out)
    );

    // Destination choice, write gating and result clearing for illegal words.
    always_comb begin
        dest_idx = ctrl.dest_is_rt ? rt_idx : rd_idx;
        wr_en    = ctrl.legal && (dest_idx != '0);
        result   = ctrl.legal ? alu_out : '0;
    end

endmodule

// File: rtl/ieu_exec_checker.sv
`timescale 1ns/1ps
// Port-level checks for int_exec_unit; attached by bind, drives nothing.
module ieu_exec_checker
    import ieu_pkg::*;
(
    input logic [INSN_W-1:0] instr,
    input logic [31:0]       result,
    input logic [REG_W-1:0]  dest,
    input logic              wr_en
);

    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic        rfmt;
    logic        immf;

    // Field views and format classes for the checks.
    always_comb begin
        opc  = instr[31:26];
        fn   = instr[5:0];
        sh   = instr[10:6];
        rfmt = (opc == 6'b000000);
        immf = (opc == 6'b001000) || (opc == 6'b001010) || (opc == 6'b001100)
            || (opc == 6'b001101) || (opc == 6'b001111);
    end

    // Settled-value checks on the outputs.
    always_comb begin
        if (dest == 5'd0) AST_NO_WRITE_R0: assert (!wr_en); // R11
        if (rfmt && wr_en) AST_RFMT_DEST_RD: assert (dest == instr[15:11]); // R1
        if (immf) AST_IMM_DEST_RT: assert (dest == instr[20:16]); // R6
        if (!rfmt && !immf) AST_UNKNOWN_OPC_QUIET: assert (!wr_en && result == 32'd0); // R10
        if (opc == 6'b001111) AST_LUI_PLACEMENT: assert (result == {instr[15:0], 16'h0000}); // R9
        if ((rfmt && fn == 6'b101010) || opc == 6'b001010) AST_SLT_IS_BOOL: assert (result[31:1] == 31'd0); // R4
        if (rfmt && fn == 6'b000000) AST_SLL_ZERO_FILL: assert ((result & ((32'd1 << sh) - 32'd1)) == 32'd0); // R5
        if (rfmt && fn == 6'b000010) AST_SRL_ZERO_FILL: assert ((result & ~(32'hFFFF_FFFF >> sh)) == 32'd0); // R5
    end

endmodule

bind int_exec_unit ieu_exec_checker u_chk (
    .instr  (instr),
    .result (result),
    .dest   (dest_idx),
    .wr_en  (wr_en)
);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit dut (
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .result   (result),
        .dest_idx (dest_idx),
        .wr_en    (wr_en)
    );

    // Behavioural reference derived from the requirements.
    function automatic void model(input logic [31:0] w, input logic [31:0] a,
                                  input logic [31:0] b, output logic [31:0] r,
                                  output logic [4:0] d, output logic we,
                                  output logic ok, output string tag);
        int sh;
        logic [31:0] se;
        logic [31:0] ze;
        sh  = int'(w[10:6]);
        se  = {{16{w[15]}}, w[15:0]};
        ze  = {16'h0000, w[15:0]};
        ok  = 1'b1;
        r   = 32'd0;
        tag = "R10";
        if (w[31:26] == 6'd0) begin
            d = w[15:11];
            case (w[5:0])
                6'h20: begin r = a + b; tag = "R1"; end
                6'h22: begin r = a - b; tag = "R2"; end
                6'h24: begin r = a & b; tag = "R2"; end
                6'h25: begin r = a | b; tag = "R2"; end
                6'h27: begin r = ~(a | b); tag = "R3"; end
                6'h2a: begin r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
                6'h00: begin r = b << sh; tag = "R5"; end
                6'h02: begin r = b >> sh; tag = "R5"; end
                default: ok = 1'b0;
            endcase
        end else begin
            d = w[20:16];
            case (w[31:26])
                6'h08: begin r = a + se; tag = "R6"; end
                6'h0a: begin r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; tag = "R7"; end
                6'h0c: begin r = a & ze; tag = "R8"; end
                6'h0d: begin r = a | ze; tag = "R8"; end
                6'h0f: begin r = {w[15:0], 16'h0000}; tag = "R9"; end
                default: ok = 1'b0;
            endcase
        end
        if (!ok) r = 32'd0;
        we = ok && (d != 5'd0);
        if (ok && d == 5'd0) tag = "R11";
    endfunction

    // Compare all three outputs against the model.
    task automatic compare(input string note);
        logic [31:0] er;
        logic [4:0]  ed;
        logic        ewe;
        logic        eok;
        string       tag;
        model(instr, rs_val, rt_val, er, ed, ewe, eok, tag);
        checks++;
        if (result !== er || wr_en !== ewe || (eok && dest_idx !== ed)) begin
            failures++;
            $display("FAIL %s %s instr=%h: got result=%h dest=%0d we=%0b, expected result=%h dest=%0d we=%0b",
                     tag, note, instr, result, dest_idx, wr_en, er, ed, ewe);
        end
    endtask

    // Apply one vector after a clock edge and check it mid-cycle.
    task automatic apply(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input string note);
        @(posedge clk);
        instr  = w;
        rs_val = a;
        rt_val = b;
        #1;
        compare(note);
    endtask

    function automatic logic [31:0] rw(input logic [5:0] fn, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [4:0] sh);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] k);
        return {op, rs, rt, k};
    endfunction

    initial begin
        // Reset phase: all-zero word is a shift into register 0 (R11).
        repeat (3) @(posedge clk);
        #1;
        compare("reset-state zero word");
        rst_n = 1'b1;

        apply(rw(6'h20, 5'd17, 5'd18, 5'd9, 5'd0), 32'd100, 32'd23, "R1 add to reg 9");
        apply(rw(6'h20, 5'd1, 5'd2, 5'd3, 5'd0), 32'hFFFF_FFFF, 32'd2, "R1 add wraps");
        apply(rw(6'h22, 5'd1, 5'd2, 5'd4, 5'd0), 32'd0, 32'd1, "R2 sub wraps");
        apply(rw(6'h24, 5'd1, 5'd2, 5'd5, 5'd0), 32'hF0F0_1234, 32'h0FF0_FF00, "R2 and");
        apply(rw(6'h25, 5'd1, 5'd2, 5'd6, 5'd0), 32'hF000_0001, 32'h0000_0F00, "R2 or");
        apply(rw(6'h27, 5'd1, 5'd0, 5'd7, 5'd0), 32'h1234_5678, 32'd0, "R3 nor as not");
        apply(rw(6'h2a, 5'd1, 5'd2, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'd1, "R4 -1<1");
        apply(rw(6'h2a, 5'd1, 5'd2, 5'd8, 5'd0), 32'd1, 32'hFFFF_FFFF, "R4 1<-1");
        apply(rw(6'h2a, 5'd1, 5'd2, 5'd8, 5'd0), 32'h8000_0000, 32'h7FFF_FFFF, "R4 min<max");
        apply(rw(6'h00, 5'd1, 5'd2, 5'd9, 5'd31), 32'hFFFF_FFFF, 32'h0000_0003, "R5 sll 31");
        apply(rw(6'h02, 5'd1, 5'd2, 5'd9, 5'd31), 32'hFFFF_FFFF, 32'h8000_0000, "R5 srl 31");
        apply(rw(6'h02, 5'd1, 5'd2, 5'd9, 5'd0), 32'd0, 32'hDEAD_BEEF, "R5 srl 0");
        apply(iw(6'h08, 5'd3, 5'd10, 16'hFFFF), 32'd5, 32'd77, "R6 addi negative");
        apply(iw(6'h08, 5'd3, 5'd11, 16'hF800), 32'd5, 32'd77, "R6 addi rd bits set");
        apply(iw(6'h0a, 5'd3, 5'd12, 16'h8000), 32'hFFFF_0000, 32'd0, "R7 slti min const");
        apply(iw(6'h0a, 5'd3, 5'd12, 16'h0001), 32'hFFFF_FFFF, 32'd0, "R7 slti -1<1");
        apply(iw(6'h0c, 5'd3, 5'd13, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, "R8 andi zext");
        apply(iw(6'h0d, 5'd3, 5'd14, 16'h8001), 32'h1000_0000, 32'd0, "R8 ori zext");
        apply(iw(6'h0f, 5'd3, 5'd15, 16'hAAAA), 32'h1234_5678, 32'd0, "R9 lui");
        apply(rw(6'h3f, 5'd1, 5'd2, 5'd16, 5'd0), 32'd9, 32'd9, "R10 bad funct");
        apply(rw(6'h21, 5'd1, 5'd2, 5'd16, 5'd0), 32'd9, 32'd9, "R10 funct next to add");
        apply(iw(6'h02, 5'd1, 5'd17, 16'h0004), 32'd9, 32'd9, "R10 bad opcode");
        apply(iw(6'h09, 5'd1, 5'd17, 16'h0004), 32'd9, 32'd9, "R10 opcode next to addi");
        apply(rw(6'h20, 5'd1, 5'd2, 5'd0, 5'd0), 32'd3, 32'd4, "R11 add to reg 0");
        apply(iw(6'h0f, 5'd1, 5'd0, 16'h1234), 32'd0, 32'd0, "R11 lui to reg 0");

        // Mixed random vectors over all forms.
        for (int n = 0; n < 600; n++) begin
            logic [5:0] fns [8];
            logic [5:0] ops [5];
            logic [31:0] w;
            int kind;
            fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2a, 6'h00, 6'h02};
            ops = '{6'h08, 6'h0a, 6'h0c, 6'h0d, 6'h0f};
            kind = $urandom_range(0, 14);
            w = $urandom;
            if (kind < 8)       w = {6'd0, w[25:6], fns[kind]};
            else if (kind < 13) w = {ops[kind-8], w[25:0]};
            else if (kind == 13) w[31:26] = 6'd0;
            apply(w, $urandom, (n % 4 == 0) ? 32'd0 : $urandom, "random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule